// File: doc/BRIEF.md
# Programmable Feedback and Output Clock Divider with Test Selector

This block sits after the oscillator of a frequency synthesizer and runs on the oscillator-rate clock. It makes two divided clocks from it. The feedback clock divides by a programmable ratio M and goes back to the phase comparator. The output clock divides by 1, 2, 4 or 8 and drives two identical true/complement output pairs. A single test pin can show one of four sources: a constant low, the raw serial configuration bit, the feedback clock or the output clock.

The M ratio, the output divide code and the test code come from an external configuration loader. A ratio change never produces a short feedback period, because the new M is taken only at a terminal count. An output code change is taken only when the internal three-bit phase counter wraps, so the output clock stays glitch-free. An active-high master reset holds both dividers and forces the output pairs to the differential low state. The configuration inputs are not touched by the reset, so the programmed ratios apply again as soon as the reset is released.

Top module: `vco_div_core`

## Requirements
- R1: The output divide code `out_code` selects the ratio: 2'b00 divides by 1 (the output follows the input clock), 2'b01 by 2, 2'b10 by 4 and 2'b11 by 8.
- R2: For ratios 2, 4 and 8 the output clock is high for exactly half of each period.
- R3: The feedback clock has a period of M input cycles and is high for floor(M/2) of them. M values below 2 are treated as 2.
- R4: While `master_rst` is high, both true outputs are low and both complement outputs are high at once, without waiting for a clock edge, and the feedback clock is low. At the first clock edge after release, the feedback clock goes high. For ratios above 1 the output clock also goes high at that edge.
- R5: Test code 2'b00 drives `test_pin` low, 2'b01 drives it with `ser_bit`, 2'b10 with the feedback clock and 2'b11 with the output clock.
- R6: While `par_mode` is high, `test_pin` is low whatever the test code.
- R7: Both output pairs carry the same clock, and each complement output is always the inverse of its true output.
- R8: A new M applied in the middle of a feedback period does not change that period. The period after the next terminal count uses the new M.
- R9: A new output code takes effect only when the phase counter wraps. The counter wraps at the 1st, 9th, 17th and later clock edges after reset release. Until then the old ratio continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Oscillator-rate input clock |
| master_rst | input | 1 | Active-high synchronous divider reset; forces the output pairs low at once |
| fb_mult | input | 9 | Feedback ratio M |
| out_code | input | 2 | Output divide code |
| test_code | input | 2 | Test pin source code |
| par_mode | input | 1 | Parallel configuration mode flag; forces the test pin low |
| ser_bit | input | 1 | Raw serial configuration data bit |
| fb_clk | output | 1 | Feedback clock, divided by M |
| out_p0 | output | 1 | Output pair 0, true |
| out_n0 | output | 1 | Output pair 0, complement |
| out_p1 | output | 1 | Output pair 1, true |
| out_n1 | output | 1 | Output pair 1, complement |
| test_pin | output | 1 | Test output |

## Verification
The hardest cases to reach from the ports are the two deferred loads. A new M or a new output code must arrive in the middle of a period and must still be held back until the divider's own wrap point. The bench gets there by counting edges from the reset release, which gives a known phase. It changes M three cycles after a feedback rising edge and changes the output code at the third edge after release. It then checks each sampled cycle against the expected old and new waveforms, up to and past the wrap.

// File: rtl/vcd_pkg.sv
// Shared definitions for the oscillator-rate divider block.
// Assumes a 2-bit test source code and a 2-bit output divide code.
package vcd_pkg;
    // Test pin source selection encodings
    typedef enum logic [1:0] {
        TSRC_LOW = 2'b00,
        TSRC_SER = 2'b01,
        TSRC_FB  = 2'b10,
        TSRC_OUT = 2'b11
    } tsrc_e;
endpackage

// File: rtl/vcd_fb_div.sv
// Feedback divider: divides clk_vco by M and gives a clock that is high
// for floor(M/2) cycles of each period. M is sampled only at the terminal
// count, so a ratio change never shortens a period. M below M_MIN is clamped.
// Assumes a synchronous active-high divider reset.
module vcd_fb_div #(
    parameter int MW    = 9,
    parameter int M_MIN = 2
) (
    input  logic          clk_vco,
    input  logic          div_rst,
    input  logic [MW-1:0] m_in,
    output logic          fb_q
);
    logic [MW-1:0] cnt;
    logic [MW-1:0] m_act;
    logic [MW-1:0] m_eff;
    logic [MW-1:0] nxt_cnt;
    logic [MW-1:0] nxt_m;
    logic          at_term;

    // Clamp too-small ratios so that the counter always has two states
    always_comb begin
        m_eff = (m_in < MW'(M_MIN)) ? MW'(M_MIN) : m_in;
    end

    // Next count and ratio; a new ratio is taken only at the terminal count
    always_comb begin
        at_term = (cnt == m_act - MW'(1));
        nxt_cnt = at_term ? '0 : cnt + MW'(1);
        nxt_m   = at_term ? m_eff : m_act;
    end

    // Count register, active ratio and registered feedback level
    always_ff @(posedge clk_vco) begin
        if (div_rst) begin
            cnt   <= m_eff - MW'(1);
            m_act <= m_eff;
            fb_q  <= 1'b0;
        end else begin
            cnt   <= nxt_cnt;
            m_act <= nxt_m;
            fb_q  <= (nxt_cnt < (nxt_m >> 1));
        end
    end
endmodule

// File: rtl/vcd_out_div.sv
// Output divider: a free-running phase counter. For a divide code k > 0 the
// output is low-active on counter bit k-1, which gives a 50% duty cycle at
// 2**k. For code 0 the gated input clock is passed through. The code is taken
// only when the counter wraps. Assumes synchronous active-high reset.
module vcd_out_div #(
    parameter int NCW = 2
) (
    input  logic           clk_vco,
    input  logic           div_rst,
    input  logic [NCW-1:0] code_in,
    output logic           out_clk
);
    localparam int PHW = (1 << NCW) - 1;

    logic [PHW-1:0] ph;
    logic [PHW-1:0] nxt_ph;
    logic [NCW-1:0] code_act;
    logic [NCW-1:0] nxt_code;
    logic           sel_bit;
    logic           div_q;
    logic           run_q;

    // Next phase and next code; the code changes only on a counter wrap
    always_comb begin
        nxt_ph   = ph + PHW'(1);
        nxt_code = (ph == {PHW{1'b1}}) ? code_in : code_act;
        sel_bit  = 1'b0;
        for (int b = 0; b < PHW; b++) begin
            if (int'(nxt_code) == b + 1) sel_bit = nxt_ph[b];
        end
    end

    // Phase counter, active code, divided level and run flag
    always_ff @(posedge clk_vco) begin
        if (div_rst) begin
            ph       <= {PHW{1'b1}};
            code_act <= code_in;
            div_q    <= 1'b0;
            run_q    <= 1'b0;
        end else begin
            ph       <= nxt_ph;
            code_act <= nxt_code;
            div_q    <= (nxt_code == '0) ? 1'b0 : ~sel_bit;
            run_q    <= 1'b1;
        end
    end

    // Divide-by-1 passes the input clock; other codes use the register
    always_comb begin
        out_clk = (code_act == '0) ? (clk_vco & run_q) : div_q;
    end
endmodule

// File: rtl/vcd_test_sel.sv
// Test pin selector: picks low, the serial bit, the feedback clock or the
// output clock. Parallel mode forces the pin low. Purely combinational.
module vcd_test_sel (
    input  logic       par_mode,
    input  logic [1:0] sel,
    input  logic       ser_bit,
    input  logic       fb_clk,
    input  logic       out_clk,
    output logic       test_pin
);
    import vcd_pkg::*;

    // Source multiplexer with the parallel-mode override
    always_comb begin
        unique case (tsrc_e'(sel))
            TSRC_LOW: test_pin = 1'b0;
            TSRC_SER: test_pin = ser_bit;
            TSRC_FB:  test_pin = fb_clk;
            TSRC_OUT: test_pin = out_clk;
            default:  test_pin = 1'b0;
        endcase
        if (par_mode) test_pin = 1'b0;
    end
endmodule

// File: rtl/vco_div_core.sv
// Top of the divider block: the feedback divider, the output divider that
// drives two true/complement pairs, and the test pin selector. master_rst
// resets the dividers synchronously and forces the output pairs low at once.
// The configuration inputs come from an external loader and are not
// affected by the reset.
module vco_div_core #(
    parameter int MW    = 9,
    parameter int M_MIN = 2,
    parameter int NCW   = 2
) (
    input  logic           clk_vco,
    input  logic           master_rst,
    input  logic [MW-1:0]  fb_mult,
    input  logic [NCW-1:0] out_code,
    input  logic [1:0]     test_code,
    input  logic           par_mode,
    input  logic           ser_bit,
    output logic           fb_clk,
    output logic           out_p0,
    output logic           out_n0,
    output logic           out_p1,
    output logic           out_n1,
    output logic           test_pin
);
    logic fb_raw;
    logic out_raw;
    logic out_clk;

    vcd_fb_div #(.MW(MW), .M_MIN(M_MIN)) fb_div_i (
        .clk_vco (clk_vco),
        .div_rst (master_rst),
        .m_in    (fb_mult),
        .fb_q    (fb_raw)
    );

    vcd_out_div #(.NCW(NCW)) out_div_i (
        .clk_vco (clk_vco),
        .div_rst (master_rst),
        .code_in (out_code),
        .out_clk (out_raw)
    );

    // Immediate low forcing of the divided clocks while reset is high
    always_comb begin
        fb_clk  = fb_raw & ~master_rst;
        out_clk = out_raw & ~master_rst;
    end

    // Both output pairs come from the one divided clock
    always_comb begin
        out_p0 = out_clk;
        out_n0 = ~out_clk;
        out_p1 = out_clk;
        out_n1 = ~out_clk;
    end

    vcd_test_sel test_sel_i (
        .par_mode (par_mode),
        .sel      (test_code),
        .ser_bit  (ser_bit),
        .fb_clk   (fb_clk),
        .out_clk  (out_clk),
        .test_pin (test_pin)
    );
endmodule

// File: rtl/vcd_chk.sv
// Checker for vco_div_core. It watches the ports only and is attached
// to the top module with the bind below.
module vcd_chk (
    input logic       clk_vco,
    input logic       master_rst,
    input logic [1:0] test_code,
    input logic       par_mode,
    input logic       fb_clk,
    input logic       out_p0,
    input logic       out_n0,
    input logic       out_p1,
    input logic       out_n1,
    input logic       test_pin
);
    // R4
    rst_forces_low_chk: assert property (@(posedge clk_vco)
        master_rst |-> (!out_p0 && out_n0 && !out_p1 && out_n1 && !fb_clk));

    // R4
    release_fb_rise_chk: assert property (@(posedge clk_vco) disable iff (master_rst)
        $fell(master_rst) |=> fb_clk);

    // R7
    pairs_match_chk: assert property (@(posedge clk_vco) disable iff (master_rst)
        (out_p0 == out_p1) && (out_n0 == out_n1) && (out_n0 != out_p0));

    // R6
    par_mode_low_chk: assert property (@(posedge clk_vco) disable iff (master_rst)
        par_mode |-> !test_pin);

    // R5
    code_low_chk: assert property (@(posedge clk_vco) disable iff (master_rst)
        (test_code == 2'b00) |-> !test_pin);

    // R5
    code_fb_chk: assert property (@(posedge clk_vco) disable iff (master_rst)
        (!par_mode && test_code == 2'b10) |-> (test_pin == fb_clk));
endmodule

bind vco_div_core vcd_chk chk_i (
    .clk_vco    (clk_vco),
    .master_rst (master_rst),
    .test_code  (test_code),
    .par_mode   (par_mode),
    .fb_clk     (fb_clk),
    .out_p0     (out_p0),
    .out_n0     (out_n0),
    .out_p1     (out_p1),
    .out_n1     (out_n1),
    .test_pin   (test_pin)
);

// File: tb/vco_div_core_tb_top.sv
module vco_div_core_tb_top;
    logic       clk_vco = 1'b0;
    logic       master_rst = 1'b1;
    logic [8:0] fb_mult = 9'd10;
    logic [1:0] out_code = 2'b01;
    logic [1:0] test_code = 2'b00;
    logic       par_mode = 1'b0;
    logic       ser_bit = 1'b0;
    logic       fb_clk, out_p0, out_n0, out_p1, out_n1, test_pin;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    vco_div_core dut_i (
        .clk_vco(clk_vco), .master_rst(master_rst), .fb_mult(fb_mult),
        .out_code(out_code), .test_code(test_code), .par_mode(par_mode),
        .ser_bit(ser_bit), .fb_clk(fb_clk), .out_p0(out_p0), .out_n0(out_n0),
        .out_p1(out_p1), .out_n1(out_n1), .test_pin(test_pin)
    );

    always #5 clk_vco = ~clk_vco;

    // Vectors: {out_code[10:9], M[8:0]}
    localparam logic [10:0] VEC [8] = '{
        {2'd1, 9'd10}, {2'd2, 9'd28}, {2'd3, 9'd25}, {2'd1, 9'd70},
        {2'd2, 9'd13}, {2'd3, 9'd1},  {2'd2, 9'd0},  {2'd3, 9'd11}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_vco);
        #1;
    endtask

    task automatic hold_reset(input logic [1:0] code, input logic [8:0] m);
        #1;
        master_rst = 1'b1;
        out_code = code;
        fb_mult = m;
        repeat (3) @(posedge clk_vco);
        #1;
        master_rst = 1'b0;
    endtask

    // Measure high cycles and period of fb_clk (which=0) or out_p0 (which=1)
    task automatic measure(input int which, output int hi, output int per);
        logic prev, cur;
        int guard;
        prev = (which == 0) ? fb_clk : out_p0;
        guard = 0;
        do begin
            step();
            cur = (which == 0) ? fb_clk : out_p0;
            guard++;
            if (cur && !prev) break;
            prev = cur;
        end while (guard < 1000);
        hi = 1;
        per = 1;
        prev = 1'b1;
        while (per < 1000) begin
            step();
            cur = (which == 0) ? fb_clk : out_p0;
            if (cur && !prev) break;
            per++;
            if (cur) hi++;
            prev = cur;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_vco);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi, per, em, ek, bad;
        logic s_out [1:16];
        logic s_fb  [1:16];

        // R4 reset state
        test_code = 2'b11;
        repeat (2) @(posedge clk_vco);
        #1;
        chk(!out_p0 && out_n0 && !out_p1 && out_n1, "R4 reset pairs", out_p0, 0);
        chk(!fb_clk, "R4 reset fb", fb_clk, 0);
        chk(!test_pin, "R5 reset test via out clock", test_pin, 0);
        test_code = 2'b00;

        // Vector walk: R1 R2 R3
        for (int v = 0; v < 8; v++) begin
            hold_reset(VEC[v][10:9], VEC[v][8:0]);
            em = (VEC[v][8:0] < 2) ? 2 : int'(VEC[v][8:0]);
            ek = 1 << VEC[v][10:9];
            measure(0, hi, per);
            chk(per == em, "R3 fb period", per, em);
            chk(hi == em / 2, "R3 fb high", hi, em / 2);
            measure(1, hi, per);
            chk(per == ek, "R1 out period", per, ek);
            chk(hi == ek / 2, "R2 out duty", hi, ek / 2);
        end

        // R1 divide by 1 follows the input clock
        hold_reset(2'b00, 9'd10);
        repeat (3) @(posedge clk_vco);
        #2;
        chk(out_p0 && !out_n0 && out_p1, "R1 div1 high phase", out_p0, 1);
        @(negedge clk_vco);
        #2;
        chk(!out_p0 && out_n0, "R1 div1 low phase", out_p0, 0);

        // R5 / R6 test selector
        hold_reset(2'b10, 9'd10);
        step();
        test_code = 2'b01; ser_bit = 1'b1; #1;
        chk(test_pin == 1'b1, "R5 code01 ser=1", test_pin, 1);
        ser_bit = 1'b0; #1;
        chk(test_pin == 1'b0, "R5 code01 ser=0", test_pin, 0);
        par_mode = 1'b1; ser_bit = 1'b1; #1;
        chk(test_pin == 1'b0, "R6 parallel forces low", test_pin, 0);
        test_code = 2'b11; #1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin step(); if (test_pin) bad++; end
        chk(bad == 0, "R6 parallel code11", bad, 0);
        par_mode = 1'b0;
        test_code = 2'b10;
        bad = 0;
        for (int i = 0; i < 20; i++) begin step(); if (test_pin !== fb_clk) bad++; end
        chk(bad == 0, "R5 code10 follows fb", bad, 0);
        test_code = 2'b11;
        bad = 0;
        for (int i = 0; i < 20; i++) begin step(); if (test_pin !== out_p0) bad++; end
        chk(bad == 0, "R5 code11 follows out", bad, 0);
        test_code = 2'b00;
        bad = 0;
        for (int i = 0; i < 10; i++) begin step(); if (test_pin) bad++; end
        chk(bad == 0, "R5 code00 low", bad, 0);

        // R4 mid-run reset forces the pairs at once, before any edge
        step();
        while (!out_p0) step();
        master_rst = 1'b1; #1;
        chk(!out_p0 && out_n0 && !out_p1 && out_n1, "R4 immediate force", out_p0, 0);
        @(posedge clk_vco); #1;

        // R9 / R4: code change at edge 3 after release, applied at edge 9
        hold_reset(2'b01, 9'd10);
        for (int i = 1; i <= 16; i++) begin
            step();
            s_out[i] = out_p0;
            s_fb[i] = fb_clk;
            if (i == 3) out_code = 2'b11;
        end
        bad = 0;
        for (int i = 4; i <= 8; i++) if (s_out[i] !== ((i % 2) == 1)) bad++;
        chk(bad == 0, "R9 old code kept until wrap", bad, 0);
        bad = 0;
        for (int i = 9; i <= 16; i++) if (s_out[i] !== (i <= 12)) bad++;
        chk(bad == 0, "R9 new code after wrap", bad, 0);
        bad = 0;
        for (int i = 1; i <= 16; i++) if (s_fb[i] !== (((i - 1) % 10) < 5)) bad++;
        chk(bad == 0, "R4 fb rises at first edge after release", bad, 0);
        chk(s_out[1] == 1'b1, "R4 out rises at first edge", s_out[1], 1);

        // R8: M change mid-period waits for the terminal count
        hold_reset(2'b01, 9'd10);
        step();
        while (fb_clk) step();
        while (!fb_clk) step();
        per = 1;
        begin
            logic prev;
            prev = 1'b1;
            while (per < 200) begin
                step();
                if (fb_clk && !prev) break;
                per++;
                if (per == 4) fb_mult = 9'd20;
                prev = fb_clk;
            end
        end
        chk(per == 10, "R8 current period keeps old M", per, 10);
        measure(0, hi, per);
        chk(per == 20, "R8 new M period", per, 20);
        chk(hi == 10, "R8 new M high", hi, 10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule